// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the 32 data words of a 3D geometry coprocessor. A host reaches them through one index and one data port. A write takes effect at the next rising clock edge. A read returns the word selected by the index combinationally, from the registered state. Most indices are plain 32-bit storage. Some carry a side effect on access:

- 16-bit sign or zero extension;
- a three-deep screen-XY FIFO, pushed through one index;
- a read-only mirror of the newest screen-XY entry;
- conversion of 5:5:5 packed colour to and from the three IR channels;
- an automatic count of leading bits.

The arithmetic datapath has three more ports that shift entries in one clock: the screen-XY, screen-Z and colour FIFOs. The block has no state machine. Every host write is first sorted by its index into one of seven access classes (`wr_kind_e`), and that class decides the update:

- `KIND_PLAIN`: full-word store;
- `KIND_SEXT`: sign extend;
- `KIND_ZEXT`: zero extend;
- `KIND_SXY_ENTRY`: FIFO push;
- `KIND_COLOR_IN`: colour expansion;
- `KIND_LEAD_SRC`: store plus leading-bit count;
- `KIND_READONLY`: discard.

There are no transitions between classes. Each write is classified on its own, in the cycle it is presented.

Top module: `cop_data_regfile`

## Requirements
- R1: A host write to index 1, 3, 5, 8, 9, 10 or 11 stores bits 15:0 of the data, sign-extended to 32 bits.
- R2: A host write to index 7, 16, 17, 18 or 19 stores bits 15:0 of the data, zero-extended to 32 bits.
- R3: A host write to index 15 moves entry 13 to entry 12 and entry 14 to entry 13, and stores the written word in entry 14. A read of index 15 returns entry 14.
- R4: A host write to index 28 sets IR1 (index 9), IR2 (index 10) and IR3 (index 11) to 0x80 times data bits 4:0, 9:5 and 14:10 respectively. Each result is zero-extended.
- R5: A read of index 28 or 29 returns a packed word: IR1 in bits 4:0, IR2 in bits 9:5 and IR3 in bits 14:10, with bits 31:15 zero. Each field is the entry value divided by 0x80. A negative entry gives 0, and a quotient above 31 gives 31.
- R6: A host write to index 30 stores the word. Index 31 is then set to the number of consecutive bits, counted from bit 31 downward, that equal bit 31. The count ranges from 1 to 32.
- R7: Host writes to index 29 and index 31 change nothing.
- R8: A screen-Z push moves entry 17 to entry 16, 18 to 17 and 19 to 18, and stores the zero-extended 16-bit value in entry 19.
- R9: A colour push moves entry 21 to entry 20 and entry 22 to entry 21. It stores R in bits 7:0, G in bits 15:8, B in bits 23:16 and the code byte in bits 31:24 of entry 22.
- R10: A screen-XY push moves entry 13 to entry 12 and entry 14 to entry 13. It stores X in bits 15:0 and Y in bits 31:16 of entry 14.
- R11: When a host write and an internal push update the same entry in one cycle, the push value is stored.
- R12: A synchronous reset sets all 32 entries to zero, so index 31 and the packed colour reads also return zero.
- R13: A host write to any index not named above stores the full 32-bit word, and reading that index returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_wr_en | input | 1 | Host write strobe |
| host_idx | input | 5 | Entry index for both reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for host_idx |
| sxy_push | input | 1 | Screen-XY FIFO push from the datapath |
| sxy_push_x | input | 16 | X value for the screen-XY push |
| sxy_push_y | input | 16 | Y value for the screen-XY push |
| sz_push | input | 1 | Screen-Z FIFO push from the datapath |
| sz_push_val | input | 16 | Depth value for the screen-Z push |
| rgb_push | input | 1 | Colour FIFO push from the datapath |
| rgb_push_r | input | 8 | Red byte |
| rgb_push_g | input | 8 | Green byte |
| rgb_push_b | input | 8 | Blue byte |
| rgb_push_code | input | 8 | Code byte |

## Verification
A fault in the class decode shows up on the first read-back after a write to the misclassified index: wrong upper bits, or a word where the mirror or packed form was expected. A broken FIFO shift is first visible when entry 12, 13, 16 or 21 is read after a push. That read happens one cycle after the push, so the fault appears at the ports within a single clock. Errors in the leading-bit count or the 5:5:5 clamp appear only for the values that reach their edges. The bench therefore uses the count extremes 1 and 32 and quotients that overflow, go negative and truncate to zero.

// File: rtl/cop_reg_pkg.sv
package cop_reg_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int NUM_ENT = 32;
    localparam int IDX_W   = $clog2(NUM_ENT);
    localparam int CFLD_W  = 5;
    localparam int CSHIFT  = 7;
    localparam int BYTE_W  = 8;

    localparam int IDX_IR1      = 9;
    localparam int IDX_IR2      = 10;
    localparam int IDX_IR3      = 11;
    localparam int IDX_SXY0     = 12;
    localparam int IDX_SXY1     = 13;
    localparam int IDX_SXY2     = 14;
    localparam int IDX_SXY_PUSH = 15;
    localparam int IDX_SZ0      = 16;
    localparam int IDX_SZ1      = 17;
    localparam int IDX_SZ2      = 18;
    localparam int IDX_SZ3      = 19;
    localparam int IDX_RGB0     = 20;
    localparam int IDX_RGB1     = 21;
    localparam int IDX_RGB2     = 22;
    localparam int IDX_COL_IN   = 28;
    localparam int IDX_COL_OUT  = 29;
    localparam int IDX_LEAD_SRC = 30;
    localparam int IDX_LEAD_CNT = 31;

    typedef enum logic [2:0] {
        KIND_PLAIN,
        KIND_SEXT,
        KIND_ZEXT,
        KIND_SXY_ENTRY,
        KIND_COLOR_IN,
        KIND_LEAD_SRC,
        KIND_READONLY
    } wr_kind_e;
endpackage

// File: rtl/cop_idx_classify.sv
module cop_idx_classify
    import cop_reg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output wr_kind_e         kind
);
    always_comb begin
        unique case (idx)
            5'd1, 5'd3, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11: kind = KIND_SEXT;
            5'd7, 5'd16, 5'd17, 5'd18, 5'd19:           kind = KIND_ZEXT;
            5'd15:                                      kind = KIND_SXY_ENTRY;
            5'd28:                                      kind = KIND_COLOR_IN;
            5'd30:                                      kind = KIND_LEAD_SRC;
            5'd29, 5'd31:                               kind = KIND_READONLY;
            default:                                    kind = KIND_PLAIN;
        endcase
    end
endmodule

// File: rtl/cop_lead_count.sv
module cop_lead_count #(
    parameter int W     = 32,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     val,
    output logic [CNT_W-1:0] cnt
);
    logic [W-1:0] norm;
    logic         found;

    // Flip the word when bit W-1 is set, so the count becomes a leading-zero count.
    assign norm = val ^ {W{val[W-1]}};

    always_comb begin
        cnt   = CNT_W'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && norm[i]) begin
                cnt   = CNT_W'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cop_rgb555_pack.sv
module cop_rgb555_pack
    import cop_reg_pkg::*;
(
    input  logic [3*WORD_W-1:0] ir_flat,
    output logic [3*CFLD_W-1:0] packed_col
);
    localparam int TOP_KEEP = CSHIFT + CFLD_W;

    for (genvar g = 0; g < 3; g++) begin : g_chan
        logic [WORD_W-1:0] chan;
        assign chan = ir_flat[g*WORD_W +: WORD_W];
        // Negative clamps to 0; any bit at TOP_KEEP or above means the quotient exceeds the field.
        assign packed_col[g*CFLD_W +: CFLD_W] =
            chan[WORD_W-1]               ? '0 :
            (|chan[WORD_W-2:TOP_KEEP])   ? {CFLD_W{1'b1}} :
                                           chan[TOP_KEEP-1:CSHIFT];
    end
endmodule

// File: rtl/cop_data_regfile.sv
module cop_data_regfile
    import cop_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              sxy_push,
    input  logic [HALF_W-1:0] sxy_push_x,
    input  logic [HALF_W-1:0] sxy_push_y,
    input  logic              sz_push,
    input  logic [HALF_W-1:0] sz_push_val,
    input  logic              rgb_push,
    input  logic [BYTE_W-1:0] rgb_push_r,
    input  logic [BYTE_W-1:0] rgb_push_g,
    input  logic [BYTE_W-1:0] rgb_push_b,
    input  logic [BYTE_W-1:0] rgb_push_code
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0]   ent_q [NUM_ENT];
    logic [WORD_W-1:0]   ent_d [NUM_ENT];
    wr_kind_e            wr_kind;
    logic [CNT_W-1:0]    lead_cnt;
    logic [3*CFLD_W-1:0] col_packed;

    cop_idx_classify u_classify (
        .idx  (host_idx),
        .kind (wr_kind)
    );

    cop_lead_count #(.W(WORD_W)) u_lead (
        .val (host_wdata),
        .cnt (lead_cnt)
    );

    cop_rgb555_pack u_pack (
        .ir_flat    ({ent_q[IDX_IR3], ent_q[IDX_IR2], ent_q[IDX_IR1]}),
        .packed_col (col_packed)
    );

    function automatic logic [WORD_W-1:0] expand_field(input logic [CFLD_W-1:0] f);
        return {{(WORD_W-CFLD_W-CSHIFT){1'b0}}, f, {CSHIFT{1'b0}}};
    endfunction

    // Next state: host effect first, then the internal pushes, which override it.
    always_comb begin
        ent_d = ent_q;
        if (host_wr_en) begin
            unique case (wr_kind)
                KIND_PLAIN: ent_d[host_idx] = host_wdata;
                KIND_SEXT:  ent_d[host_idx] = {{HALF_W{host_wdata[HALF_W-1]}}, host_wdata[HALF_W-1:0]};
                KIND_ZEXT:  ent_d[host_idx] = {{HALF_W{1'b0}}, host_wdata[HALF_W-1:0]};
                KIND_SXY_ENTRY: begin
                    ent_d[IDX_SXY0] = ent_q[IDX_SXY1];
                    ent_d[IDX_SXY1] = ent_q[IDX_SXY2];
                    ent_d[IDX_SXY2] = host_wdata;
                end
                KIND_COLOR_IN: begin
                    ent_d[IDX_COL_IN] = {{(WORD_W-3*CFLD_W){1'b0}}, host_wdata[3*CFLD_W-1:0]};
                    ent_d[IDX_IR1]    = expand_field(host_wdata[0*CFLD_W +: CFLD_W]);
                    ent_d[IDX_IR2]    = expand_field(host_wdata[1*CFLD_W +: CFLD_W]);
                    ent_d[IDX_IR3]    = expand_field(host_wdata[2*CFLD_W +: CFLD_W]);
                end
                KIND_LEAD_SRC: begin
                    ent_d[IDX_LEAD_SRC] = host_wdata;
                    ent_d[IDX_LEAD_CNT] = {{(WORD_W-CNT_W){1'b0}}, lead_cnt};
                end
                KIND_READONLY: ;
            endcase
        end
        if (sxy_push) begin
            ent_d[IDX_SXY0] = ent_q[IDX_SXY1];
            ent_d[IDX_SXY1] = ent_q[IDX_SXY2];
            ent_d[IDX_SXY2] = {sxy_push_y, sxy_push_x};
        end
        if (sz_push) begin
            ent_d[IDX_SZ0] = ent_q[IDX_SZ1];
            ent_d[IDX_SZ1] = ent_q[IDX_SZ2];
            ent_d[IDX_SZ2] = ent_q[IDX_SZ3];
            ent_d[IDX_SZ3] = {{HALF_W{1'b0}}, sz_push_val};
        end
        if (rgb_push) begin
            ent_d[IDX_RGB0] = ent_q[IDX_RGB1];
            ent_d[IDX_RGB1] = ent_q[IDX_RGB2];
            ent_d[IDX_RGB2] = {rgb_push_code, rgb_push_b, rgb_push_g, rgb_push_r};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        if (host_idx == IDX_W'(IDX_SXY_PUSH))
            host_rdata = ent_q[IDX_SXY2];
        else if (host_idx == IDX_W'(IDX_COL_IN) || host_idx == IDX_W'(IDX_COL_OUT))
            host_rdata = {{(WORD_W-3*CFLD_W){1'b0}}, col_packed};
        else
            host_rdata = ent_q[host_idx];
    end

    // ---------------- assertions ----------------
    logic [IDX_W-1:0] chk_idx_q;
    wr_kind_e         chk_kind_q;
    logic             chk_wr_q;
    always_ff @(posedge clk) begin
        chk_idx_q  <= host_idx;
        chk_kind_q <= wr_kind;
        chk_wr_q   <= host_wr_en && !rst;
    end

    always @(negedge clk) begin
        if (!rst && chk_wr_q && chk_kind_q == KIND_SEXT)
            assert_sext_upper_R1: assert (ent_q[chk_idx_q][WORD_W-1:HALF_W] == {HALF_W{ent_q[chk_idx_q][HALF_W-1]}})
                else $error("sign extension broken");
        if (!rst && chk_wr_q && chk_kind_q == KIND_ZEXT)
            assert_zext_upper_R2: assert (ent_q[chk_idx_q][WORD_W-1:HALF_W] == '0)
                else $error("zero extension broken");
    end

    assert_sxy_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_idx == IDX_W'(IDX_SXY_PUSH) && !sxy_push) |=>
        (ent_q[IDX_SXY0] == $past(ent_q[IDX_SXY1]) && ent_q[IDX_SXY1] == $past(ent_q[IDX_SXY2])
         && ent_q[IDX_SXY2] == $past(host_wdata)));

    assert_lead_range_R6: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_idx == IDX_W'(IDX_LEAD_SRC)) |=>
        (ent_q[IDX_LEAD_CNT] >= 1 && ent_q[IDX_LEAD_CNT] <= WORD_W));

    assert_cnt_readonly_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_idx == IDX_W'(IDX_LEAD_CNT)) |=> $stable(ent_q[IDX_LEAD_CNT]));

    assert_sz_shift_R8: assert property (@(posedge clk) disable iff (rst)
        sz_push |=> (ent_q[IDX_SZ0] == $past(ent_q[IDX_SZ1]) && ent_q[IDX_SZ2] == $past(ent_q[IDX_SZ3])));

    assert_sz_push_wins_R11: assert property (@(posedge clk) disable iff (rst)
        sz_push |=> ent_q[IDX_SZ3] == {{HALF_W{1'b0}}, $past(sz_push_val)});

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (ent_q[0] == '0 && ent_q[IDX_SXY2] == '0 && ent_q[IDX_LEAD_CNT] == '0));
endmodule

// File: tb/sim_cop_data_regfile.sv
`timescale 1ns/1ps
module sim_cop_data_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr_en;
    logic [4:0]  host_idx;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        sxy_push, sz_push, rgb_push;
    logic [15:0] sxy_push_x, sxy_push_y, sz_push_val;
    logic [7:0]  rgb_push_r, rgb_push_g, rgb_push_b, rgb_push_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cop_data_regfile u0 (
        .clk, .rst, .host_wr_en, .host_idx, .host_wdata, .host_rdata,
        .sxy_push, .sxy_push_x, .sxy_push_y, .sz_push, .sz_push_val,
        .rgb_push, .rgb_push_r, .rgb_push_g, .rgb_push_b, .rgb_push_code
    );

    typedef struct packed {
        logic [4:0]  widx;
        logic [31:0] wdata;
        logic [4:0]  ridx;
        logic [31:0] expv;
        logic [23:0] tag;
    } vec_t;

    localparam int NVEC = 26;
    // Each row: write wdata to widx, then read ridx and expect expv.
    localparam vec_t VECS [NVEC] = '{
        '{5'd0,  32'hDEADBEEF, 5'd0,  32'hDEADBEEF, "R13"},
        '{5'd1,  32'h12348001, 5'd1,  32'hFFFF8001, "R1 "},
        '{5'd3,  32'hABCD7FFF, 5'd3,  32'h00007FFF, "R1 "},
        '{5'd8,  32'h0000F000, 5'd8,  32'hFFFFF000, "R1 "},
        '{5'd7,  32'hFFFF9ABC, 5'd7,  32'h00009ABC, "R2 "},
        '{5'd19, 32'h8765FFFF, 5'd19, 32'h0000FFFF, "R2 "},
        '{5'd30, 32'h00000000, 5'd31, 32'd32,       "R6 "},
        '{5'd30, 32'hFFFFFFFF, 5'd31, 32'd32,       "R6 "},
        '{5'd30, 32'h00010000, 5'd31, 32'd15,       "R6 "},
        '{5'd30, 32'h80000000, 5'd31, 32'd1,        "R6 "},
        '{5'd30, 32'hF0F00000, 5'd30, 32'hF0F00000, "R6 "},
        '{5'd28, 32'hFFFF7C1F, 5'd9,  32'h00000F80, "R4 "},
        '{5'd28, 32'h000003E0, 5'd10, 32'h00000F80, "R4 "},
        '{5'd23, 32'h00000001, 5'd28, 32'h000003E0, "R5 "},
        '{5'd9,  32'h00007FFF, 5'd29, 32'h000003FF, "R5 "},
        '{5'd10, 32'hFFFF8000, 5'd28, 32'h0000001F, "R5 "},
        '{5'd11, 32'h000000FF, 5'd28, 32'h0000041F, "R5 "},
        '{5'd11, 32'h0000007F, 5'd28, 32'h0000001F, "R5 "},
        '{5'd29, 32'h12345678, 5'd29, 32'h0000001F, "R7 "},
        '{5'd31, 32'h00000005, 5'd31, 32'd4,        "R7 "},
        '{5'd12, 32'h0000000A, 5'd12, 32'h0000000A, "R13"},
        '{5'd13, 32'h0000000B, 5'd13, 32'h0000000B, "R13"},
        '{5'd14, 32'h0000000C, 5'd15, 32'h0000000C, "R3 "},
        '{5'd15, 32'h0000000D, 5'd12, 32'h0000000B, "R3 "},
        '{5'd15, 32'h0000000E, 5'd13, 32'h0000000D, "R3 "},
        '{5'd15, 32'h0000000F, 5'd15, 32'h0000000F, "R3 "}
    };

    task automatic check_read(input logic [4:0] idx, input logic [31:0] expv, input string tag);
        host_idx = idx;
        #1;
        n_checks++;
        if (host_rdata !== expv) begin
            n_fail++;
            $display("FAIL %s idx %0d: actual %h expected %h", tag, idx, host_rdata, expv);
        end
    endtask

    task automatic host_write(input logic [4:0] idx, input logic [31:0] data);
        @(negedge clk);
        host_wr_en = 1'b1; host_idx = idx; host_wdata = data;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic idle_pushes();
        sxy_push = 1'b0; sz_push = 1'b0; rgb_push = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; host_wr_en = 1'b0; host_idx = '0; host_wdata = '0;
        sxy_push_x = '0; sxy_push_y = '0; sz_push_val = '0;
        rgb_push_r = '0; rgb_push_g = '0; rgb_push_b = '0; rgb_push_code = '0;
        idle_pushes();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        check_read(5'd0,  32'h0, "R12");
        check_read(5'd31, 32'h0, "R12");
        check_read(5'd28, 32'h0, "R12");

        for (int i = 0; i < NVEC; i++) begin
            host_write(VECS[i].widx, VECS[i].wdata);
            check_read(VECS[i].ridx, VECS[i].expv, string'(VECS[i].tag));
        end

        // R10: internal screen-XY push, state 12=D 13=E 14=F
        @(negedge clk);
        sxy_push = 1'b1; sxy_push_x = 16'h0123; sxy_push_y = 16'hFF80;
        @(negedge clk);
        idle_pushes();
        check_read(5'd12, 32'h0000000E, "R10");
        check_read(5'd13, 32'h0000000F, "R10");
        check_read(5'd15, 32'hFF800123, "R10");

        // R11: host write to 15 collides with screen-XY push
        @(negedge clk);
        host_wr_en = 1'b1; host_idx = 5'd15; host_wdata = 32'h00000099;
        sxy_push = 1'b1; sxy_push_x = 16'h0001; sxy_push_y = 16'h0002;
        @(negedge clk);
        host_wr_en = 1'b0; idle_pushes();
        check_read(5'd14, 32'h00020001, "R11");
        check_read(5'd13, 32'hFF800123, "R11");

        // R8: screen-Z pushes; SZ starts 0,0,0,FFFF
        @(negedge clk);
        sz_push = 1'b1; sz_push_val = 16'h1111;
        @(negedge clk);
        sz_push_val = 16'h2222;
        @(negedge clk);
        idle_pushes();
        check_read(5'd17, 32'h0000FFFF, "R8");
        check_read(5'd18, 32'h00001111, "R8");
        check_read(5'd19, 32'h00002222, "R8");

        // R11: host write to 17 collides with screen-Z push
        @(negedge clk);
        host_wr_en = 1'b1; host_idx = 5'd17; host_wdata = 32'h00005555;
        sz_push = 1'b1; sz_push_val = 16'h3333;
        @(negedge clk);
        host_wr_en = 1'b0; idle_pushes();
        check_read(5'd17, 32'h00001111, "R11");
        check_read(5'd16, 32'h0000FFFF, "R8");

        // R9: colour pushes
        @(negedge clk);
        rgb_push = 1'b1;
        rgb_push_r = 8'h11; rgb_push_g = 8'h22; rgb_push_b = 8'h33; rgb_push_code = 8'h44;
        @(negedge clk);
        rgb_push_r = 8'hAA; rgb_push_g = 8'hBB; rgb_push_b = 8'hCC; rgb_push_code = 8'hDD;
        @(negedge clk);
        idle_pushes();
        check_read(5'd21, 32'h44332211, "R9");
        check_read(5'd22, 32'hDDCCBBAA, "R9");
        check_read(5'd20, 32'h00000000, "R9");

        // R12: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_read(5'd22, 32'h0, "R12");
        check_read(5'd0,  32'h0, "R12");
        check_read(5'd29, 32'h0, "R12");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule